// File: doc/BRIEF.md
# Ratio Clock Divider with Quarter-Speed Shift

This block turns one fast internal base clock (400 MHz by default) into a processor clock, a peripheral-bus clock and an IO clock by integer division. A frequency select picks a processor clock of 100 MHz (select high) or 66.67 MHz (select low). The bus clock stays at 33.3 MHz in both cases, so it is one third of the processor clock in the fast setting and half of it in the slow one. An active-low quarter-speed control may change at any time. While it is low, both the processor and bus clocks run at one quarter of their normal rate. A change of either control takes effect only at the next bus-clock rising edge, so no output ever emits a partial period.

Two straps are captured once, on the first base-clock edge after reset is released, and are then held until the next reset. One strap picks a 48 MHz or a 24 MHz IO clock. The IO clock comes from a phase accumulator, so its average rate is exact. The other strap is a test strap. When it is low, the output-enable that drives the pad buffers is held off and every clock output is held low, which places the pads in high impedance.

Top module: `ratio_clk_divider`

## Requirements
- R1: While reset is asserted, the processor, bus and IO clock outputs and the output-enable are all 0.
- R2: With select = 1 and quarter control = 1 (inactive), the processor clock period is 4 base cycles and the bus clock period is 12 base cycles.
- R3: With select = 0 and quarter control = 1, the processor clock period is 6 base cycles and the bus clock period is 12 base cycles.
- R4: With quarter control = 0, the processor clock period is 16 base cycles (select = 1) or 24 base cycles (select = 0), and the bus clock period is 48 base cycles.
- R5: The high time of the processor and bus clocks is exactly half of their period in every setting.
- R6: Every rising edge of the bus clock falls in the same base cycle as a rising edge of the processor clock.
- R7: A change of the quarter control is applied only at a bus-clock boundary. While the change takes effect, every processor period is either the old or the new value, and the new period appears within 25 processor cycles.
- R8: With the IO strap at 0 the IO clock averages 48 MHz (300 ± 1 rising edges per 2500 base cycles). With the strap at 1 it averages 24 MHz (150 ± 1).
- R9: With the test strap at 0 the output-enable stays 0 and all clock outputs stay low. With the strap at 1 the output-enable is 1.
- R10: Both straps are captured on the first base-clock edge after reset is released. Later changes on the strap inputs have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock (400 MHz nominal) |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_fast | input | 1 | 1: 100 MHz processor clock, 0: 66.67 MHz |
| quarter_n | input | 1 | Active-low quarter-speed control, asynchronous to the block |
| strap_io | input | 1 | IO clock strap: 0 gives 48 MHz, 1 gives 24 MHz |
| strap_test_n | input | 1 | Test strap: 0 disables all outputs (high impedance) |
| cpu_clk | output | 1 | Processor clock |
| pci_clk | output | 1 | Bus clock |
| io_clk | output | 1 | IO clock |
| out_en | output | 1 | Output-enable for the clock pad buffers |

## Verification
The hardest situation to reach is a run-time quarter-speed change that lands in the middle of a bus period. The new rate must appear only at the next common boundary, with no shortened or stretched processor period in between. The bench reaches it by toggling the quarter control at an arbitrary base cycle while the clocks are running. It then times every processor rising edge that follows and accepts only the old period or the new period, until the new period shows up within the allowed number of cycles. Strap retention is reached by changing the strap pins a few cycles after reset is released, then measuring the IO clock rate and the output-enable that follow.

// File: rtl/ratio_clk_pkg.sv
// Shared types for the ratio clock divider.
// Assumes: nothing beyond IEEE 1800-2017.
package ratio_clk_pkg;

    // Active ratio setting applied to the processor and bus dividers
    typedef struct packed {
        logic fast;     // 1: fast processor ratio
        logic quarter;  // 1: quarter-speed shift active
    } ratio_cfg_t;

endpackage

// File: rtl/ratio_sync.sv
// Two-flop synchronizer for level controls that may change at any time.
// Assumes: inputs are quasi-static levels; resets to RST_VAL.
module ratio_sync #(
    parameter int unsigned W       = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Two-stage capture of the asynchronous levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/strap_latch.sv
// Captures the power-on straps once after reset release and holds them.
// Assumes: straps are stable around the first edge after reset.
module strap_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic strap_io,
    input  logic strap_test_n,
    output logic io_slow,
    output logic enable
);
    logic done_q;

    // One-shot capture on the first edge after reset release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            io_slow <= 1'b0;
            enable  <= 1'b0;
        end else if (!done_q) begin
            done_q  <= 1'b1;
            io_slow <= strap_io;
            enable  <= strap_test_n;
        end
    end

    // R10
    strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(done_q) |-> ($stable(io_slow) && $stable(enable)));
endmodule

// File: rtl/ratio_divider.sv
// Processor and bus clock dividers sharing one aligned phase counter.
// Assumes: every processor divisor divides the bus period; all divisors even.
// A new ratio is loaded only on the last base cycle of a bus period.
module ratio_divider
    import ratio_clk_pkg::*;
#(
    parameter int unsigned CPU_DIV_FAST = 4,
    parameter int unsigned CPU_DIV_SLOW = 6,
    parameter int unsigned PCI_DIV      = 12,
    parameter int unsigned QUARTER      = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_fast_s,
    input  logic quarter_s,
    output logic cpu_q,
    output logic pci_q
);
    localparam int unsigned PER_MAX = PCI_DIV * QUARTER;
    localparam int unsigned CW      = $clog2(PER_MAX + 1);

    function automatic logic [CW-1:0] bus_per(input logic q);
        return q ? CW'(PER_MAX) : CW'(PCI_DIV);
    endfunction

    function automatic logic [CW-1:0] cpu_per(input logic f, input logic q);
        int unsigned base;
        base = f ? CPU_DIV_FAST : CPU_DIV_SLOW;
        return q ? CW'(base * QUARTER) : CW'(base);
    endfunction

    ratio_cfg_t    cfg_q, nxt_cfg;
    logic [CW-1:0] cnt_p, cnt_c, nxt_p, nxt_c, per_c, nxt_per_p, nxt_per_c;
    logic          last_p;

    // Next counter values and the ratio that applies to them
    always_comb begin
        last_p    = (cnt_p == bus_per(cfg_q.quarter) - CW'(1));
        per_c     = cpu_per(cfg_q.fast, cfg_q.quarter);
        nxt_cfg   = last_p ? '{fast: sel_fast_s, quarter: quarter_s} : cfg_q;
        nxt_per_p = bus_per(nxt_cfg.quarter);
        nxt_per_c = cpu_per(nxt_cfg.fast, nxt_cfg.quarter);
        nxt_p     = last_p ? '0 : cnt_p + CW'(1);
        nxt_c     = (last_p || cnt_c == per_c - CW'(1)) ? '0 : cnt_c + CW'(1);
    end

    // Phase counters, ratio register and registered clock levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '{fast: 1'b1, quarter: 1'b0};
            cnt_p <= '0;
            cnt_c <= '0;
            cpu_q <= 1'b0;
            pci_q <= 1'b0;
        end else begin
            cfg_q <= nxt_cfg;
            cnt_p <= nxt_p;
            cnt_c <= nxt_c;
            cpu_q <= (nxt_c < (nxt_per_c >> 1));
            pci_q <= (nxt_p < (nxt_per_p >> 1));
        end
    end

    // R6
    pci_rise_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pci_q) |-> $rose(cpu_q));
    // R6
    phase_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_p == '0) |-> (cnt_c == '0));
    // R7
    cfg_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_p != '0) |-> $stable(cfg_q));
endmodule

// File: rtl/io_nco.sv
// IO clock from a phase accumulator: average rate base*INC/(2*MOD) for the
// full-rate output, half of that for the slow output.
// Assumes: INC < MOD.
module io_nco #(
    parameter int unsigned IO_INC = 12,
    parameter int unsigned IO_MOD = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow,
    output logic io_q
);
    localparam int unsigned AW = $clog2(IO_MOD + IO_INC + 1);

    logic [AW-1:0] acc_q, sum;
    logic          full_q, half_q, wrap;

    // Accumulator sum and wrap detection
    always_comb begin
        sum  = acc_q + AW'(IO_INC);
        wrap = (sum >= AW'(IO_MOD));
    end

    // Accumulator and toggle flops for both IO rates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            full_q <= 1'b0;
            half_q <= 1'b0;
        end else begin
            acc_q <= wrap ? sum - AW'(IO_MOD) : sum;
            if (wrap) begin
                full_q <= ~full_q;
                if (!full_q) half_q <= ~half_q;
            end
        end
    end

    assign io_q = slow ? half_q : full_q;

    // R8
    acc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q < AW'(IO_MOD));
    // R8
    half_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(half_q) |-> $rose(full_q));
endmodule

// File: rtl/ratio_clk_divider.sv
// Top: processor/bus ratio divider with quarter-speed shift, strap-selected
// IO clock and test-mode output disable.
// Assumes: clk is the base clock; sel_fast and quarter_n may change at any time.
module ratio_clk_divider #(
    parameter int unsigned CPU_DIV_FAST = 4,
    parameter int unsigned CPU_DIV_SLOW = 6,
    parameter int unsigned PCI_DIV      = 12,
    parameter int unsigned QUARTER      = 4,
    parameter int unsigned IO_INC       = 12,
    parameter int unsigned IO_MOD       = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_fast,
    input  logic quarter_n,
    input  logic strap_io,
    input  logic strap_test_n,
    output logic cpu_clk,
    output logic pci_clk,
    output logic io_clk,
    output logic out_en
);
    logic [1:0] sync_q;
    logic       io_slow, enable, cpu_q, pci_q, io_q;

    ratio_sync #(.W(2), .RST_VAL(2'b10)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({sel_fast, ~quarter_n}), .q(sync_q)
    );

    strap_latch u_strap (
        .clk(clk), .rst_n(rst_n), .strap_io(strap_io),
        .strap_test_n(strap_test_n), .io_slow(io_slow), .enable(enable)
    );

    ratio_divider #(
        .CPU_DIV_FAST(CPU_DIV_FAST), .CPU_DIV_SLOW(CPU_DIV_SLOW),
        .PCI_DIV(PCI_DIV), .QUARTER(QUARTER)
    ) u_div (
        .clk(clk), .rst_n(rst_n), .sel_fast_s(sync_q[1]),
        .quarter_s(sync_q[0]), .cpu_q(cpu_q), .pci_q(pci_q)
    );

    io_nco #(.IO_INC(IO_INC), .IO_MOD(IO_MOD)) u_io (
        .clk(clk), .rst_n(rst_n), .slow(io_slow), .io_q(io_q)
    );

    assign out_en  = enable;
    assign cpu_clk = cpu_q & enable;
    assign pci_clk = pci_q & enable;
    assign io_clk  = io_q  & enable;
endmodule

// File: tb/ratio_clk_divider_test.sv
module ratio_clk_divider_test;
    localparam int CLK_PERIOD = 10;
    // sel_fast, quarter_n, expected cpu period, expected bus period
    localparam int VEC[4][4] = '{'{1, 1, 4, 12}, '{0, 1, 6, 12},
                                 '{1, 0, 16, 48}, '{0, 0, 24, 48}};

    logic clk = 1'b0, rst_n = 1'b0;
    logic sel_fast = 1'b1, quarter_n = 1'b1, strap_io = 1'b0, strap_test_n = 1'b1;
    logic cpu_clk, pci_clk, io_clk, out_en;
    int checks = 0, errors = 0;

    // sampler state, updated at the falling edge
    int cyc = 0, cpu_rise = 0, cpu_per = 0, cpu_high = 0, cpu_nrise = 0;
    int pci_rise = 0, pci_per = 0, pci_high = 0, io_rises = 0, misalign = 0;
    logic cpu_prev = 1'b0, pci_prev = 1'b0, io_prev = 1'b0;

    ratio_clk_divider uut (
        .clk(clk), .rst_n(rst_n), .sel_fast(sel_fast), .quarter_n(quarter_n),
        .strap_io(strap_io), .strap_test_n(strap_test_n),
        .cpu_clk(cpu_clk), .pci_clk(pci_clk), .io_clk(io_clk), .out_en(out_en)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (cpu_clk && !cpu_prev) begin
            cpu_per   <= cyc - cpu_rise;
            cpu_rise  <= cyc;
            cpu_nrise <= cpu_nrise + 1;
        end
        if (!cpu_clk && cpu_prev) cpu_high <= cyc - cpu_rise;
        if (pci_clk && !pci_prev) begin
            pci_per  <= cyc - pci_rise;
            pci_rise <= cyc;
            if (!(cpu_clk && !cpu_prev)) misalign <= misalign + 1;
        end
        if (!pci_clk && pci_prev) pci_high <= cyc - pci_rise;
        if (io_clk && !io_prev) io_rises <= io_rises + 1;
        cpu_prev <= cpu_clk;
        pci_prev <= pci_clk;
        io_prev  <= io_clk;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(4);
        rst_n = 1'b1;
        step(2);
    endtask

    // quarter control change: count processor edges until the new period
    task automatic shift_test(input logic new_qn, input int old_p, input int new_p);
        int n0, last, bad;
        bool_loop: begin
            n0 = cpu_nrise; last = cpu_nrise; bad = 0;
            quarter_n = new_qn;
            for (int i = 0; i < 1000; i++) begin
                step(1);
                if (cpu_nrise != last) begin
                    last = cpu_nrise;
                    if (cpu_per != old_p && cpu_per != new_p) bad++;
                    if (cpu_per == new_p) break;
                end
            end
            chk("R7 partial periods", bad, 0);
            chk_rng("R7 settle cycles", cpu_nrise - n0, 1, 25);
            chk("R7 new period", cpu_per, new_p);
        end
    endtask

    initial begin
        int r0;
        // R1 reset state
        step(5);
        chk("R1 cpu_clk", int'(cpu_clk), 0);
        chk("R1 pci_clk", int'(pci_clk), 0);
        chk("R1 io_clk", int'(io_clk), 0);
        chk("R1 out_en", int'(out_en), 0);
        rst_n = 1'b1;
        step(2);
        chk("R9 out_en normal", int'(out_en), 1);

        // ratio table: R2 R3 R4 with R5 duty
        for (int v = 0; v < 4; v++) begin
            string tag;
            tag = (VEC[v][1] == 0) ? "R4" : (VEC[v][0] == 1 ? "R2" : "R3");
            sel_fast  = VEC[v][0][0];
            quarter_n = VEC[v][1][0];
            step(200);
            chk({tag, " cpu period"}, cpu_per, VEC[v][2]);
            chk({tag, " pci period"}, pci_per, VEC[v][3]);
            chk("R5 cpu high", cpu_high, VEC[v][2] / 2);
            chk("R5 pci high", pci_high, VEC[v][3] / 2);
        end

        // R7 run-time shift in both directions, off a boundary
        sel_fast = 1'b1; quarter_n = 1'b1;
        step(205);
        shift_test(1'b0, 4, 16);
        step(151);
        shift_test(1'b1, 16, 4);

        // R8 48 MHz IO clock
        r0 = io_rises;
        step(2500);
        chk_rng("R8 io 48MHz rises", io_rises - r0, 299, 301);

        // R8 R10: 24 MHz strap, then strap pin changes after capture
        strap_io = 1'b1;
        do_reset();
        strap_io = 1'b0;
        step(100);
        r0 = io_rises;
        step(2500);
        chk_rng("R10 io strap held 24MHz rises", io_rises - r0, 149, 151);

        // R9 R10: test strap low, then released after capture
        strap_test_n = 1'b0;
        do_reset();
        strap_test_n = 1'b1;
        r0 = cpu_nrise;
        step(200);
        chk("R9 out_en test mode", int'(out_en), 0);
        chk("R10 test strap held", cpu_nrise - r0, 0);
        chk("R9 pci low in test mode", int'(pci_clk), 0);

        // R6 alignment over the whole run
        chk("R6 misaligned bus edges", misalign, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule